// File: doc/BRIEF.md
# Stacked Clear-on-Read DMA Interrupt Status Register

This block holds the DMA-side interrupt status of a bus-master controller as an 8-bit read-only register. Qualified event inputs set individual status bits. A host read, marked by a one-cycle strobe, returns the current value on `rd_data`. The read clears the interrupt bits that were set at that moment.

Interrupts are stacked in a second stage. An event that arrives while visible interrupt bits are still pending is held there, and it moves into the visible register once a read has cleared the current set. Because of this, the register can read non-zero again right after a read.

A summary pending flag records that a DMA interrupt was visible, and a read clears it. A registered interrupt line is the OR of the visible interrupt bits, each ANDed with its bit from an externally held enable value. Bit 7 reports the live FIFO-empty level and never interrupts. All pins are plain control and status signals. No data is streamed, so there is no valid/ready handshake and no back-pressure.

Top module: `dma_int_status`

## Requirements
- R1: After reset, `rd_data` reads 0x80 while `fifo_empty` is high, and `irq` and `dma_pend` are 0.
- R2: A read (`rd_strobe` high for one cycle) clears every interrupt bit that was visible at that edge. The visible register then takes the stacked bits on the same edge.
- R3: While any visible interrupt bit is set and no read occurs, the visible bits hold. New events go into the stacking stage and appear only after a read.
- R4: An event in the same cycle as a read is stacked. It becomes visible one cycle after the read, when the register is otherwise empty.
- R5: `dma_pend` sets on the edge after a visible interrupt bit is present and stays set. A read clears it at the read edge.
- R6: `irq` is registered. On each edge it takes the OR over bits 6..2 and bit 0 of (visible AND `int_en`). Bits 7 and 1 of `int_en` have no effect.
- R7: Bit 7 of `rd_data` equals `fifo_empty` combinationally. A read does not clear it, and it never raises `irq`.
- R8: Bit 6 (parity) sets when `par_chk_en` is high and either `mst_active & mst_par_err` or `tgt_par_err` holds. With `par_chk_en` low it never sets.
- R9: Bit 5 (bus fault) sets only when `mst_active` is high and `cyc_bad_addr` or `cyc_tgt_abort` is high.
- R10: Bit 4 sets on `abort_evt`, bit 3 on `sstep_evt`, bit 2 on `sir_evt` and bit 0 on `iid_evt`. Bit 1 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_strobe | input | 1 | Host read of the register completes this cycle |
| rd_data | output | 8 | Register read value |
| fifo_empty | input | 1 | Live DMA FIFO empty level |
| mst_active | input | 1 | Block currently owns the bus as master |
| mst_par_err | input | 1 | Data parity error detected as master |
| tgt_par_err | input | 1 | Parity error signalled as target in a data phase |
| par_chk_en | input | 1 | Master parity error enable |
| cyc_bad_addr | input | 1 | Bus cycle ended with a bad address |
| cyc_tgt_abort | input | 1 | Bus cycle ended with a target abort |
| abort_evt | input | 1 | Abort event |
| sstep_evt | input | 1 | Single-step event |
| sir_evt | input | 1 | Script interrupt instruction event |
| iid_evt | input | 1 | Illegal instruction event |
| int_en | input | 8 | Per-bit interrupt enable |
| dma_pend | output | 1 | Summary DMA interrupt pending flag |
| irq | output | 1 | Masked interrupt request |

## Verification
A host read and a new event can fall on the same clock edge. Stacking and clearing then collide, and an event could be lost or shown too early. The bench provokes this by raising `sir_evt` in the exact cycle of `rd_strobe` with an empty stack. It expects 0x80 on the next cycle and the event bit the cycle after. A second scenario raises one event while another is visible. It checks that the first read shows only the earlier bit and the second read shows the later one.

// File: rtl/dstat_pkg.sv
package dstat_pkg;
  localparam int ST_W = 8;
  localparam int B_FE   = 7;
  localparam int B_PAR  = 6;
  localparam int B_BF   = 5;
  localparam int B_ABT  = 4;
  localparam int B_SS   = 3;
  localparam int B_SIR  = 2;
  localparam int B_RSV  = 1;
  localparam int B_IID  = 0;
  localparam logic [ST_W-1:0] INT_MASK =
    ST_W'((1 << B_PAR) | (1 << B_BF) | (1 << B_ABT) |
          (1 << B_SS) | (1 << B_SIR) | (1 << B_IID));
endpackage

// File: rtl/dstat_evt_qual.sv
module dstat_evt_qual
  import dstat_pkg::*;
(
  input  logic            mst_active,
  input  logic            mst_par_err,
  input  logic            tgt_par_err,
  input  logic            par_chk_en,
  input  logic            cyc_bad_addr,
  input  logic            cyc_tgt_abort,
  input  logic            abort_evt,
  input  logic            sstep_evt,
  input  logic            sir_evt,
  input  logic            iid_evt,
  output logic [ST_W-1:0] ev
);
  always_comb begin
    ev = '0;
    ev[B_PAR] = par_chk_en & ((mst_active & mst_par_err) | tgt_par_err);
    ev[B_BF]  = mst_active & (cyc_bad_addr | cyc_tgt_abort);
    ev[B_ABT] = abort_evt;
    ev[B_SS]  = sstep_evt;
    ev[B_SIR] = sir_evt;
    ev[B_IID] = iid_evt;
  end
endmodule

// File: rtl/dstat_stack.sv
module dstat_stack
  import dstat_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd,
  input  logic [ST_W-1:0] ev,
  output logic [ST_W-1:0] vis,
  output logic [ST_W-1:0] stk
);
  logic [ST_W-1:0] vis_n, stk_n, ev_m;

  assign ev_m = ev & INT_MASK;

  always_comb begin
    if (rd) begin
      vis_n = stk;
      stk_n = ev_m;
    end else if (vis == '0) begin
      vis_n = stk | ev_m;
      stk_n = '0;
    end else begin
      vis_n = vis;
      stk_n = stk | ev_m;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vis <= '0;
      stk <= '0;
    end else begin
      vis <= vis_n;
      stk <= stk_n;
    end
  end

  // R2
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> ((vis & $past(vis) & ~$past(stk)) == '0));
  // R3
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd && vis != '0) |=> (vis == $past(vis)));
  // R4
  same_cycle_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && ev_m != '0) |=> ((stk & $past(ev_m)) == $past(ev_m)));
endmodule

// File: rtl/dstat_irq_out.sv
module dstat_irq_out
  import dstat_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd,
  input  logic [ST_W-1:0] vis,
  input  logic [ST_W-1:0] en,
  output logic            irq,
  output logic            pend
);
  logic any_en, any_vis;

  assign any_en  = |(vis & en & INT_MASK);
  assign any_vis = |(vis & INT_MASK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq  <= 1'b0;
      pend <= 1'b0;
    end else begin
      irq  <= any_en;
      pend <= rd ? 1'b0 : (pend | any_vis);
    end
  end

  // R6
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past((vis & en & INT_MASK) != '0));
  // R5
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> !pend);
endmodule

// File: rtl/dma_int_status.sv
module dma_int_status
  import dstat_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_strobe,
  output logic [ST_W-1:0] rd_data,
  input  logic            fifo_empty,
  input  logic            mst_active,
  input  logic            mst_par_err,
  input  logic            tgt_par_err,
  input  logic            par_chk_en,
  input  logic            cyc_bad_addr,
  input  logic            cyc_tgt_abort,
  input  logic            abort_evt,
  input  logic            sstep_evt,
  input  logic            sir_evt,
  input  logic            iid_evt,
  input  logic [ST_W-1:0] int_en,
  output logic            dma_pend,
  output logic            irq
);
  logic [ST_W-1:0] ev, vis, stk;

  dstat_evt_qual u_qual (
    .mst_active(mst_active), .mst_par_err(mst_par_err),
    .tgt_par_err(tgt_par_err), .par_chk_en(par_chk_en),
    .cyc_bad_addr(cyc_bad_addr), .cyc_tgt_abort(cyc_tgt_abort),
    .abort_evt(abort_evt), .sstep_evt(sstep_evt),
    .sir_evt(sir_evt), .iid_evt(iid_evt), .ev(ev)
  );

  dstat_stack u_stack (
    .clk(clk), .rst_n(rst_n), .rd(rd_strobe), .ev(ev),
    .vis(vis), .stk(stk)
  );

  dstat_irq_out u_irq (
    .clk(clk), .rst_n(rst_n), .rd(rd_strobe), .vis(vis), .en(int_en),
    .irq(irq), .pend(dma_pend)
  );

  always_comb begin
    rd_data = vis & INT_MASK;
    rd_data[B_FE] = fifo_empty;
  end

  // R7
  fe_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((vis & INT_MASK) == '0) |=> !irq);
  // R10
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_strobe) |-> (stk[B_RSV] == 1'b0));
endmodule

// File: tb/test_dma_int_status.sv
module test_dma_int_status;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_strobe = 1'b0;
  logic [7:0] rd_data;
  logic fifo_empty = 1'b1;
  logic mst_active = 1'b0, mst_par_err = 1'b0, tgt_par_err = 1'b0;
  logic par_chk_en = 1'b1, cyc_bad_addr = 1'b0, cyc_tgt_abort = 1'b0;
  logic abort_evt = 1'b0, sstep_evt = 1'b0, sir_evt = 1'b0, iid_evt = 1'b0;
  logic [7:0] int_en = 8'h00;
  logic dma_pend, irq;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dma_int_status i_dma_int_status (
    .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .rd_data(rd_data),
    .fifo_empty(fifo_empty), .mst_active(mst_active),
    .mst_par_err(mst_par_err), .tgt_par_err(tgt_par_err),
    .par_chk_en(par_chk_en), .cyc_bad_addr(cyc_bad_addr),
    .cyc_tgt_abort(cyc_tgt_abort), .abort_evt(abort_evt),
    .sstep_evt(sstep_evt), .sir_evt(sir_evt), .iid_evt(iid_evt),
    .int_en(int_en), .dma_pend(dma_pend), .irq(irq)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle_ev();
    mst_active = 0; mst_par_err = 0; tgt_par_err = 0; par_chk_en = 1;
    cyc_bad_addr = 0; cyc_tgt_abort = 0;
    abort_evt = 0; sstep_evt = 0; sir_evt = 0; iid_evt = 0;
  endtask

  // drive events by expected-bit pattern (bits 6,5,4,3,2,0)
  task automatic drive_ev(logic [7:0] p);
    mst_active = 1; par_chk_en = 1;
    mst_par_err = p[6]; cyc_bad_addr = p[5];
    abort_evt = p[4]; sstep_evt = p[3]; sir_evt = p[2]; iid_evt = p[0];
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_read();
    rd_strobe = 1; step(); rd_strobe = 0;
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    // R1
    chk("R1 rd_data", rd_data, 8'h80);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 pend", {7'd0, dma_pend}, 8'h00);

    // sweep of all event patterns with varying enables
    for (int k = 0; k < 64; k++) begin
      logic [7:0] p, en;
      p = {1'b0, k[5], k[4], k[3], k[2], k[1], 1'b0, k[0]};
      en = 8'(k * 37 + 5);
      int_en = en;
      drive_ev(p); step(); idle_ev();
      chk("R10 R8 R9 set", rd_data, p | 8'h80);
      step();
      chk("R6 irq", {7'd0, irq}, {7'd0, |(p & en & 8'h7D)});
      chk("R5 pend", {7'd0, dma_pend}, {7'd0, p != 0});
      do_read();
      chk("R2 cleared", rd_data, 8'h80);
      chk("R5 pend cleared", {7'd0, dma_pend}, 8'h00);
      step();
      chk("R6 irq low", {7'd0, irq}, 8'h00);
    end

    // R3 stacking: abort visible, then sstep arrives
    int_en = 8'hFF;
    abort_evt = 1; step(); abort_evt = 0;
    sstep_evt = 1; step(); sstep_evt = 0;
    chk("R3 only first", rd_data, 8'h90);
    step();
    chk("R3 still first", rd_data, 8'h90);
    do_read();
    chk("R3 stacked shown", rd_data, 8'h88);
    step();
    chk("R5 pend re-set", {7'd0, dma_pend}, 8'h01);
    do_read();
    chk("R2 empty", rd_data, 8'h80);

    // R4 event in same cycle as read
    iid_evt = 1; step(); iid_evt = 0;
    sir_evt = 1; rd_strobe = 1; step(); sir_evt = 0; rd_strobe = 0;
    chk("R4 read cycle", rd_data, 8'h80);
    step();
    chk("R4 appears", rd_data, 8'h84);
    do_read(); step();

    // R8 parity disabled, target parity, R9 no bus fault without master
    par_chk_en = 0; mst_active = 1; mst_par_err = 1; step(); idle_ev();
    chk("R8 disabled", rd_data, 8'h80);
    tgt_par_err = 1; step(); idle_ev();
    chk("R8 target", rd_data, 8'hC0);
    do_read();
    mst_active = 0; cyc_bad_addr = 1; cyc_tgt_abort = 1; step(); idle_ev();
    chk("R9 not master", rd_data, 8'h80);
    mst_active = 1; cyc_tgt_abort = 1; step(); idle_ev();
    chk("R9 tabort", rd_data, 8'hA0);
    do_read();

    // R7 fifo-empty is live, not cleared, no irq
    fifo_empty = 0; int_en = 8'hFF; step();
    chk("R7 live low", rd_data, 8'h00);
    fifo_empty = 1; do_read();
    chk("R7 not cleared", rd_data, 8'h80);
    step();
    chk("R7 no irq", {7'd0, irq}, 8'h00);
    // R6 enable bits 7 and 1 ignored
    int_en = 8'h82; sir_evt = 1; step(); sir_evt = 0; step();
    chk("R6 masked", {7'd0, irq}, 8'h00);
    do_read();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule